// File: doc/BRIEF.md
# Platform Level Interrupt Controller

This block collects level-sensitive interrupt lines from peripherals and routes them to a small number of processor contexts. Each source has a programmable priority. Each context has its own enable bits and its own priority threshold. For every context the block finds the best pending source that is enabled for that context and whose priority is above that context's threshold. While such a source exists, the block raises that context's interrupt output.

Software handles an interrupt in two steps through a single register per context. A read of that register returns the ID of the winning source. The read also takes the source out of the pending set and holds it as in service, so that no context sees it again. When handling is finished, software writes the same ID back to the register. The source is then released, and if its line is still high it becomes pending again. ID 0 means "no source": a read that returns 0 tells software that nothing is left to handle.

The register port is a plain single-cycle request port. Read data comes back one cycle after the request. The address map uses fixed strides, so a driver can compute each register address from a source ID or a context number.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, enable bit and threshold is 0, every interrupt output is low, and a claim read returns 0.
- R2: The priority of source n (n ≥ 1) is at byte address 4·n. It keeps only its low 3 bits: higher write bits are dropped and read back as 0. Address 0 (source 0) always reads 0 and ignores writes.
- R3: The enables of context c start at 0x2000 + 0x80·c, one bit per source. Source n is in word n/32 (address offset 4·(n/32)) at bit n%32. Bit 0 of word 0 reads 0. A source counts only for the contexts that enable it.
- R4: A source is eligible for a context only when its priority is strictly greater than that context's threshold. With threshold 7 no source is eligible. With threshold 0 every source with a nonzero priority is eligible, and a source with priority 0 never is.
- R5: The output irq_o[c] is a registered signal. It is high one clock after context c has at least one eligible pending source, and it stays high while any such source remains.
- R6: A read of the claim register at 0x200004 + 0x1000·c returns the winning source ID for context c. The winner is the eligible pending source with the highest priority. On equal priorities the lowest ID wins. If no source is eligible, the read returns 0.
- R7: A claim read that returns a nonzero ID clears that source's pending state and marks it in service. An in-service source is offered to no context, even if its line stays high.
- R8: Writing an ID to a context's claim register releases that source from service only if the source is in service and is enabled for the writing context. Any other completion write is ignored.
- R9: A source line that is high while the source is not in service latches a pending state. That state stays set until the source is claimed, even if the line drops. After a completion, a line that is still high becomes pending again, and a line that is low leaves the source idle.
- R10: The threshold of context c is at 0x200000 + 0x1000·c. It keeps its low 3 bits and reads them back.
- R11: A read request returns its data on rdata_o with rvalid_o high in the next cycle. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| rvalid_o | output | 1 | Read data valid |
| src_i | input | NUM_SRC | Level interrupt lines; bit k is source ID k+1 |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The bench raises three sources together, two of them at the same priority. It expects the claims to come back highest priority first and then lowest ID first; a design with a backwards priority loop would return the higher ID of the tied pair. After all of them are claimed, the lines stay high and the claim must return 0; a design that does not block in-service sources would hand the same ID out again. Completion writes are sent from a context that does not enable the source, and for a source whose line has dropped. A design that skips the enable check would re-arm the source too early, and one that does not track the level would report a stale source. Threshold cases cover equal priority and threshold, threshold 7, and priority 0; a design that uses ≥ instead of > raises an interrupt where none is due. A one-cycle pulse must still be claimable, which catches a design that does not latch the pending state.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W     = 22;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CTX_BASE   = 32'h0020_0000;
  localparam int unsigned CTX_STRIDE = 32'h0000_1000;
  localparam int unsigned THR_OFS    = 0;
  localparam int unsigned CLAIM_OFS  = 4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_EN,
    REG_THR,
    REG_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/irq_reg_dec.sv
module irq_reg_dec
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned ID_W    = 5,
  parameter int unsigned CTX_W   = 1,
  parameter int unsigned WORD_W  = 1,
  parameter int unsigned EN_WORDS = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [ID_W-1:0]   id_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [WORD_W-1:0] word_o
);
  int unsigned a, n, c, w, ofs;

  always_comb begin
    a      = 32'(addr_i);
    n      = 0;
    c      = 0;
    w      = 0;
    ofs    = 0;
    kind_o = REG_NONE;
    if (a[1:0] == 2'b00) begin
      if (a < 32'h1000) begin
        n = a >> 2;
        if (n >= 1 && n <= NUM_SRC) kind_o = REG_PRIO;
      end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * NUM_CTX) begin
        c = (a - EN_BASE) / EN_STRIDE;
        w = ((a - EN_BASE) % EN_STRIDE) >> 2;
        if (w < EN_WORDS) kind_o = REG_EN;
      end else if (a >= CTX_BASE && a < CTX_BASE + CTX_STRIDE * NUM_CTX) begin
        c   = (a - CTX_BASE) / CTX_STRIDE;
        ofs = (a - CTX_BASE) % CTX_STRIDE;
        if (ofs == THR_OFS)        kind_o = REG_THR;
        else if (ofs == CLAIM_OFS) kind_o = REG_CLAIM;
      end
    end
    id_o   = ID_W'(n);
    ctx_o  = CTX_W'(c);
    word_o = WORD_W'(w);
  end
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic busy_o
);
  logic pend_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (claim_i) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      if (complete_i) busy_q <= 1'b0;
      if (src_i && !busy_q) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

  AST_CLAIM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> (busy_q && !pend_q)); // R7
  AST_BUSY_NOT_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !pend_q); // R7
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC:0]               pend_i,
  input  logic [NUM_SRC:0]               en_i,
  input  logic [NUM_SRC:0][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                best_id_o,
  output logic [PRIO_W-1:0]              best_prio_o
);
  // descending scan with >= lets the lower ID win ties
  always_comb begin
    best_id_o   = '0;
    best_prio_o = '0;
    for (int i = NUM_SRC; i >= 1; i--) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) && (prio_i[i] >= best_prio_o)) begin
        best_id_o   = ID_W'(i);
        best_prio_o = prio_i[i];
      end
    end
  end

  AST_WIN_ABOVE_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id_o != '0) |-> (prio_i[best_id_o] > thr_i)); // R4
  AST_WIN_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id_o != '0) |-> (pend_i[best_id_o] && en_i[best_id_o])); // R3
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic [NUM_CTX-1:0]  irq_o
);
  localparam int unsigned ID_W     = $clog2(NUM_SRC + 1);
  localparam int unsigned CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int unsigned EN_WORDS = (NUM_SRC + 1 + 31) / 32;
  localparam int unsigned WORD_W   = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;

  reg_kind_e           dec_kind;
  logic [ID_W-1:0]     dec_id;
  logic [CTX_W-1:0]    dec_ctx;
  logic [WORD_W-1:0]   dec_word;

  logic [NUM_SRC:0][PRIO_W-1:0]              prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:0]             en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]            thr_q;
  logic [NUM_SRC:0]                          pend, busy, claim_v, done_v;
  logic [NUM_CTX-1:0][ID_W-1:0]              best_id;
  logic [NUM_CTX-1:0][PRIO_W-1:0]            best_prio;
  logic [NUM_CTX-1:0]                        irq_q;
  logic [31:0]                               rd_val, rdata_q;
  logic                                      rvalid_q, claim_rd_q, prio_rd_q;
  logic                                      rd_req, wr_req, claim_rd, done_wr;
  logic [ID_W-1:0]                           claim_id;

  irq_reg_dec #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ID_W(ID_W),
    .CTX_W(CTX_W), .WORD_W(WORD_W), .EN_WORDS(EN_WORDS)
  ) u_dec (
    .addr_i(addr_i), .kind_o(dec_kind), .id_o(dec_id),
    .ctx_o(dec_ctx), .word_o(dec_word)
  );

  assign rd_req   = req_i && !we_i;
  assign wr_req   = req_i && we_i;
  assign claim_rd = rd_req && (dec_kind == REG_CLAIM);
  assign done_wr  = wr_req && (dec_kind == REG_CLAIM);
  assign claim_id = best_id[dec_ctx];

  always_comb begin
    claim_v = '0;
    done_v  = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      claim_v[s] = claim_rd && (claim_id == ID_W'(s));
      done_v[s]  = done_wr && (wdata_i == 32'(s)) && en_q[dec_ctx][s];
    end
  end

  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    irq_src_gate u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i[s-1]),
      .claim_i(claim_v[s]), .complete_i(done_v[s]),
      .pend_o(pend[s]), .busy_o(busy[s])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_ctx_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .en_i(en_q[c]),
      .prio_i(prio_q), .thr_i(thr_q[c]),
      .best_id_o(best_id[c]), .best_prio_o(best_prio[c])
    );
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_req) begin
      case (dec_kind)
        REG_PRIO: prio_q[dec_id] <= wdata_i[PRIO_W-1:0];
        REG_THR:  thr_q[dec_ctx] <= wdata_i[PRIO_W-1:0];
        REG_EN: begin
          for (int s = 1; s <= NUM_SRC; s++)
            if ((s / 32) == int'(dec_word)) en_q[dec_ctx][s] <= wdata_i[s % 32];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (dec_kind)
      REG_PRIO:  rd_val = 32'(prio_q[dec_id]);
      REG_THR:   rd_val = 32'(thr_q[dec_ctx]);
      REG_CLAIM: rd_val = 32'(claim_id);
      REG_EN: begin
        for (int s = 1; s <= NUM_SRC; s++)
          if ((s / 32) == int'(dec_word)) rd_val[s % 32] = en_q[dec_ctx][s];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      claim_rd_q <= 1'b0;
      prio_rd_q  <= 1'b0;
      irq_q      <= '0;
    end else begin
      rvalid_q   <= rd_req;
      claim_rd_q <= claim_rd;
      prio_rd_q  <= rd_req && (dec_kind == REG_PRIO);
      if (rd_req) rdata_q <= rd_val;
      for (int c = 0; c < NUM_CTX; c++) irq_q[c] <= (best_id[c] != '0);
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = irq_q;

  AST_CLAIMED_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_q && claim_rd_q && rdata_q != '0) |-> busy[rdata_q[ID_W-1:0]]); // R7
  AST_PRIO_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_q && prio_rd_q) |-> (rdata_q[31:PRIO_W] == '0)); // R2
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NS = 31;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [21:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [NS-1:0] src = '0;
  logic [NC-1:0] irq;

  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .src_i(src), .irq_o(irq)
  );

  function automatic logic [21:0] a_prio(int id);  return 22'(4 * id); endfunction
  function automatic logic [21:0] a_en(int c, int w); return 22'(32'h2000 + 32'h80 * c + 4 * w); endfunction
  function automatic logic [21:0] a_thr(int c);   return 22'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [21:0] a_clm(int c);   return 22'(32'h20_0000 + 32'h1000 * c + 4); endfunction

  task automatic bus_write(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  // driver: push expected value, then issue read
  task automatic bus_read(logic [21:0] a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic chk_irq(logic [NC-1:0] e, string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq_o actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare read data in the order the driver queued it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_irq(2'b00, "R1 irq after reset");
    bus_read(a_prio(5), 0, "R1 prio reset");
    bus_read(a_en(0, 0), 0, "R1 enable reset");
    bus_read(a_thr(0), 0, "R1 threshold reset");
    bus_read(a_clm(0), 0, "R1 claim reset");
    // R2 priority width and ID 0
    bus_write(a_prio(3), 32'hFFFF_FFF5);
    bus_read(a_prio(3), 5, "R2 prio upper bits dropped");
    bus_write(a_prio(0), 7);
    bus_read(a_prio(0), 0, "R2 source 0 prio");
    // R10 threshold width
    bus_write(a_thr(1), 32'h1C);
    bus_read(a_thr(1), 4, "R10 threshold readback");
    // R3 enable layout
    bus_write(a_en(0, 0), 32'hFFFF_FFFF);
    bus_read(a_en(0, 0), 32'hFFFF_FFFE, "R3 enable bit0 zero");
    bus_read(22'h00_3FFC, 0, "R11 unmapped read");
    bus_write(a_prio(7), 5);
    bus_write(a_prio(10), 6);
    bus_write(a_prio(12), 2);
    bus_write(a_prio(20), 1);
    // R5/R6 ordering
    @(negedge clk);
    src[2] = 1; src[6] = 1; src[9] = 1;
    settle();
    chk_irq(2'b01, "R5 irq for ctx0 only (R3 ctx1 disabled)");
    bus_read(a_clm(0), 10, "R6 highest priority first");
    bus_read(a_clm(0), 3, "R6 tie lowest ID");
    bus_read(a_clm(0), 7, "R6 remaining");
    bus_read(a_clm(0), 0, "R7 claimed not re-presented");
    settle();
    chk_irq(2'b00, "R7 irq drops after claims");
    // R8 completion from a context without the enable
    bus_write(a_clm(1), 7);
    settle();
    chk_irq(2'b00, "R8 foreign completion ignored");
    bus_read(a_clm(0), 0, "R8 foreign completion ignored");
    bus_write(a_clm(0), 7);
    settle();
    chk_irq(2'b01, "R9 re-pend after completion");
    bus_read(a_clm(0), 7, "R8 completion re-arms");
    // R9 line dropped before completion
    @(negedge clk);
    src[9] = 0;
    bus_write(a_clm(0), 10);
    settle();
    bus_read(a_clm(0), 0, "R9 dropped line stays idle");
    // R4 strict threshold
    bus_write(a_thr(0), 5);
    bus_write(a_clm(0), 3);
    settle();
    chk_irq(2'b00, "R4 prio equal to threshold");
    bus_read(a_clm(0), 0, "R4 prio equal to threshold");
    bus_write(a_thr(0), 4);
    settle();
    chk_irq(2'b01, "R4 prio above threshold");
    bus_read(a_clm(0), 3, "R4 prio above threshold");
    bus_write(a_prio(12), 7);
    bus_write(a_thr(0), 7);
    @(negedge clk);
    src[11] = 1;
    settle();
    chk_irq(2'b00, "R4 threshold 7 masks");
    bus_read(a_clm(0), 0, "R4 threshold 7 masks");
    bus_write(a_thr(0), 0);
    bus_write(a_prio(12), 0);
    settle();
    bus_read(a_clm(0), 0, "R4 prio 0 never eligible");
    bus_write(a_prio(12), 2);
    settle();
    bus_read(a_clm(0), 12, "R4 prio 2 above threshold 0");
    // R9 pulse latch, context 1
    bus_write(a_en(1, 0), 32'h0010_0000);
    bus_write(a_thr(1), 0);
    @(negedge clk);
    src[19] = 1;
    @(negedge clk);
    src[19] = 0;
    settle();
    chk_irq(2'b11, "R9 pulse latched");
    bus_read(a_clm(1), 20, "R9 pulse claimable");
    settle();
    chk_irq(2'b00, "R7 irq low after claim");
    @(negedge clk);
    src[19] = 1;
    bus_write(a_clm(1), 20);
    settle();
    bus_read(a_clm(1), 20, "R8 completion by owner re-arms");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++;
      fails++;
      $display("FAIL R11 missing read data actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule